// File: doc/BRIEF.md
# Scaled-Add, Logic, Shift and Byte-Zap Integer Unit

This block is a single-issue 64-bit integer execution unit. Each cycle it may accept one operation, selected by a six-bit function code, on operand A and a second operand. The second operand is either the 64-bit input B or an 8-bit immediate, chosen by an immediate-select input. Four operation classes are supported. The arithmetic class adds or subtracts, optionally after scaling A by 4 or 8, in quadword (64-bit) or longword (32-bit, sign-extended) width. The logic class performs AND, OR or XOR, optionally against the complement of the second operand. The shift class shifts left or right, logically or arithmetically. The zap class clears selected byte lanes of A.

The result and a valid flag are registered, so the answer appears one clock after the operation is presented. When no operation is presented, the previous result stays on the output. There are no flags and no overflow traps.

Function code layout: bits [5:4] select the class (00 arithmetic, 01 logic, 10 shift, 11 zap). Bit [3] selects longword width in the arithmetic class. Bit [2] means subtract (arithmetic) or invert the second operand or selector (logic, zap). Bits [1:0] are the class sub-select.

Top module: `sax_alu`

## Requirements
- R1: A synchronous reset drives `out_valid` to 0 and `result` to 0 on the next clock edge.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `result` keeps its previous value.
- R3: Arithmetic class (func[5:4]=00). A is first scaled by func[1:0]: 00 ×1, 01 ×4, 1x ×8. Then the second operand is added (func[2]=0) or subtracted (func[2]=1), modulo 2^64.
- R4: With func[3]=1 in the arithmetic class, only the low 32 bits of the R3 result are kept, and they are sign-extended from bit 31 to 64 bits.
- R5: Logic class (func[5:4]=01). func[1:0] selects 00 AND, 01 OR, 1x XOR. func[2]=1 uses the bitwise complement of the second operand.
- R6: Shift class (func[5:4]=10). The count is the low 6 bits of the second operand. func[1:0]=00 shifts left and func[1:0]=01 shifts right, both filling with zeros.
- R7: Shift class with func[1]=1 shifts right arithmetically, filling with copies of A's bit 63.
- R8: Zap class (func[5:4]=11) with func[2]=0. Each set bit i of the second operand's low 8 bits zeroes byte lane i (bits 8i+7..8i) of A. Other lanes pass unchanged.
- R9: Zap class with func[2]=1 inverts the 8-bit selector first, so set bits keep their lanes and clear bits zero them.
- R10: When `use_imm` is 1, the 8-bit `imm` zero-extended to 64 bits replaces B in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| func | input | 6 | Function code |
| use_imm | input | 1 | Use `imm` instead of `opb` as second operand |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| imm | input | 8 | Immediate value |
| out_valid | output | 1 | Registered valid |
| result | output | 64 | Registered result |

## Verification
Scaling and longword truncation can act on the same operation. A scaled longword add or subtract may carry into bits above 31 and also flip bit 31. The bench provokes this with ×8 longword additions and ×4 longword subtractions, using operands whose scaled value crosses bit 31 or wraps past 2^32. The registered result must equal the 64-bit scaled sum, cut to 32 bits and sign-extended from its bit 31, with nothing from the upper carry leaking through. A second overlap is immediate selection combined with complement: an inverted immediate must turn into a value whose upper 56 bits are all ones.

// File: rtl/sax_pkg.sv
package sax_pkg;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'b00,
        CLS_LOGIC = 2'b01,
        CLS_SHIFT = 2'b10,
        CLS_ZAP   = 2'b11
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;    // [5:4]
        logic       lng;    // [3]   longword width (arithmetic)
        logic       neg;    // [2]   subtract / invert operand
        logic [1:0] sel;    // [1:0] sub-select within class
    } func_t;

    typedef struct packed {
        logic        valid;
        logic [63:0] result;
    } out_state_t;

endpackage

// File: rtl/sax_addsub.sv
module sax_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   scale,
    input  logic         sub,
    input  logic         lng,
    output logic [W-1:0] y
);
    localparam int HALF = W / 2;

    logic [W-1:0] a_scaled;
    logic [W-1:0] sum;

    always_comb begin
        case (scale)
            2'b00:   a_scaled = a;
            2'b01:   a_scaled = {a[W-3:0], 2'b00};
            default: a_scaled = {a[W-4:0], 3'b000};
        endcase
        sum = sub ? (a_scaled - b) : (a_scaled + b);
        y   = lng ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
    end

endmodule

// File: rtl/sax_shift.sv
module sax_shift #(
    parameter int W = 64
) (
    input  logic [W-1:0]         a,
    input  logic [$clog2(W)-1:0] cnt,
    input  logic [1:0]           kind,
    output logic [W-1:0]         y
);
    always_comb begin
        if (kind[1])
            y = W'($signed(a) >>> cnt);
        else if (kind[0])
            y = a >> cnt;
        else
            y = a << cnt;
    end

endmodule

// File: rtl/sax_zap.sv
module sax_zap #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W/8-1:0] lane_clr,
    output logic [W-1:0]   y
);
    localparam int LANES = W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign y[8*g +: 8] = lane_clr[g] ? 8'h00 : a[8*g +: 8];
    end

endmodule

// File: rtl/sax_alu.sv
module sax_alu #(
    parameter int W     = 64,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [5:0]       func,
    input  logic             use_imm,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [W-1:0]     result
);
    import sax_pkg::*;

    localparam int SH_W  = $clog2(W);
    localparam int LANES = W / 8;

    func_t        f;
    logic [W-1:0] b_eff;
    logic [W-1:0] arith_y;
    logic [W-1:0] shift_y;
    logic [W-1:0] zap_y;
    logic [W-1:0] logic_y;
    logic [W-1:0] b_log;
    logic [LANES-1:0] lane_sel;

    out_state_t state_d, state_q;

    assign f     = func_t'(func);
    assign b_eff = use_imm ? {{(W-IMM_W){1'b0}}, imm} : opb;

    sax_addsub #(.W(W)) u_addsub (
        .a     (opa),
        .b     (b_eff),
        .scale (f.sel),
        .sub   (f.neg),
        .lng   (f.lng),
        .y     (arith_y)
    );

    sax_shift #(.W(W)) u_shift (
        .a    (opa),
        .cnt  (b_eff[SH_W-1:0]),
        .kind (f.sel),
        .y    (shift_y)
    );

    assign lane_sel = f.neg ? ~b_eff[LANES-1:0] : b_eff[LANES-1:0];

    sax_zap #(.W(W)) u_zap (
        .a        (opa),
        .lane_clr (lane_sel),
        .y        (zap_y)
    );

    always_comb begin
        b_log = f.neg ? ~b_eff : b_eff;
        case (f.sel)
            2'b00:   logic_y = opa & b_log;
            2'b01:   logic_y = opa | b_log;
            default: logic_y = opa ^ b_log;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            case (f.cls)
                CLS_ARITH: state_d.result = arith_y;
                CLS_LOGIC: state_d.result = logic_y;
                CLS_SHIFT: state_d.result = shift_y;
                default:   state_d.result = zap_y;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.result;

endmodule

// File: rtl/sax_alu_chk.sv
module sax_alu_chk #(
    parameter int W     = 64,
    parameter int IMM_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [5:0]       func,
    input logic             use_imm,
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [IMM_W-1:0] imm,
    input logic             out_valid,
    input logic [W-1:0]     result
);
    logic [W-1:0] b_in;
    assign b_in = use_imm ? {{(W-IMM_W){1'b0}}, imm} : opb;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R2
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R4
    a_r4_long_sext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func[5:4] == 2'b00 && func[3])
        |=> (result[W-1:W/2] == {(W/2){result[W/2-1]}}));

    // R7
    a_r7_sra_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func[5:4] == 2'b10 && func[1] && opa[W-1])
        |=> result[W-1]);

    // R8
    a_r8_zap_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func[5:4] == 2'b11 && !func[2] && b_in[0])
        |=> (result[7:0] == 8'h00));

    // R9
    a_r9_zapnot_lane0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func[5:4] == 2'b11 && func[2] && !b_in[0])
        |=> (result[7:0] == 8'h00));

endmodule

bind sax_alu sax_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .func      (func),
    .use_imm   (use_imm),
    .opa       (opa),
    .opb       (opb),
    .imm       (imm),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_sax_alu.sv
`timescale 1ns/1ps
module tb_sax_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  func;
    logic        use_imm;
    logic [63:0] opa, opb;
    logic [7:0]  imm;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sax_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
        .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [5:0] fc, input logic ui,
                                          input logic [63:0] a, input logic [63:0] b0,
                                          input logic [7:0] im);
        logic [63:0] b, as, s, bb, y;
        logic [7:0]  lanes;
        b = ui ? {56'd0, im} : b0;
        y = '0;
        case (fc[5:4])
            2'b00: begin
                as = (fc[1:0] == 2'b00) ? a : (fc[1:0] == 2'b01) ? a * 64'd4 : a * 64'd8;
                s  = fc[2] ? as - b : as + b;
                y  = fc[3] ? {{32{s[31]}}, s[31:0]} : s;
            end
            2'b01: begin
                bb = fc[2] ? ~b : b;
                y  = (fc[1:0] == 2'b00) ? (a & bb) : (fc[1:0] == 2'b01) ? (a | bb) : (a ^ bb);
            end
            2'b10: begin
                if (fc[1])        y = 64'($signed(a) >>> b[5:0]);
                else if (fc[0])   y = a >> b[5:0];
                else              y = a << b[5:0];
            end
            default: begin
                lanes = fc[2] ? ~b[7:0] : b[7:0];
                y = a;
                for (int i = 0; i < 8; i++)
                    if (lanes[i]) y[8*i +: 8] = 8'h00;
            end
        endcase
        return y;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one operation, check result one clock later.
    task automatic run_op(input string req, input logic [5:0] fc, input logic ui,
                          input logic [63:0] a, input logic [63:0] b, input logic [7:0] im);
        @(negedge clk);
        in_valid = 1'b1; func = fc; use_imm = ui; opa = a; opb = b; imm = im;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, model(fc, ui, a, b, im));
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 result", result, 64'd0);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_arith;
        run_op("R3 addq wrap", 6'b000000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0);
        run_op("R3 subq wrap", 6'b000100, 0, 64'd0, 64'd1, 8'd0);
        run_op("R3 s4addq", 6'b000001, 0, 64'h4000_0000_0000_0003, 64'd5, 8'd0);
        run_op("R3 s8subq", 6'b000110, 0, 64'h0000_0000_1234_5678, 64'h100, 8'd0);
        run_op("R4 addl sext", 6'b001000, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'd0);
        run_op("R4 s8addl carry", 6'b001010, 0, 64'h0000_0000_3000_0000, 64'h0800_0000, 8'd0);
        run_op("R4 s4subl", 6'b001101, 0, 64'hABCD_0000_0000_0001, 64'd9, 8'd0);
    endtask

    task automatic t_logic;
        run_op("R5 and", 6'b010000, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF, 8'd0);
        run_op("R5 bic", 6'b010100, 0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF, 8'd0);
        run_op("R5 or", 6'b010001, 0, 64'h1, 64'h8000_0000_0000_0000, 8'd0);
        run_op("R5 ornot", 6'b010101, 0, 64'h0, 64'hFFFF_0000_FFFF_0000, 8'd0);
        run_op("R5 xor", 6'b010010, 0, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_0000_FFFF_0000, 8'd0);
        run_op("R10 xnor imm", 6'b010110, 1, 64'h0, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF);
    endtask

    task automatic t_shift;
        run_op("R6 sll cnt67", 6'b100000, 0, 64'h8000_0000_0000_0001, 64'd67, 8'd0);
        run_op("R6 srl", 6'b100001, 0, 64'h8000_0000_0000_0000, 64'd63, 8'd0);
        run_op("R7 sra neg", 6'b100010, 0, 64'h8000_0000_0000_0F00, 64'd8, 8'd0);
        run_op("R7 sra pos", 6'b100011, 0, 64'h7000_0000_0000_0000, 64'd4, 8'd0);
        run_op("R10 sll imm", 6'b100000, 1, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF, 8'd68);
    endtask

    task automatic t_zap;
        run_op("R8 zap", 6'b110000, 0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF81, 8'd0);
        run_op("R8 zap none", 6'b110000, 0, 64'h0123_4567_89AB_CDEF, 64'h100, 8'd0);
        run_op("R9 zapnot", 6'b110100, 0, 64'h0123_4567_89AB_CDEF, 64'h0F, 8'd0);
        run_op("R10 zapnot imm", 6'b110100, 1, 64'h0123_4567_89AB_CDEF, 64'hFF, 8'h30);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        run_op("R2 load", 6'b000000, 0, 64'h55, 64'h22, 8'd0);
        prev = result;
        @(negedge clk);
        in_valid = 1'b0; func = 6'b010001; opa = 64'hFFFF; opb = 64'hFFFF;
        @(negedge clk);
        check("R2 hold result", result, prev);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; func = '0; use_imm = 1'b0;
        opa = '0; opb = '0; imm = '0;
        repeat (2) @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_shift();
        t_zap();
        t_hold();
        run_op("R1 pre", 6'b000000, 0, 64'h77, 64'h1, 8'd0);
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule